// File: doc/BRIEF.md
# Banked AHB-Lite Slave Memory With Per-Bank Wait States

This block is an AHB-Lite slave that presents up to six independent memory banks inside one byte address space. Each bank is placed by a start and an end byte address (both inclusive) and carries two latency settings. The first setting is the number of wait states for the opening NONSEQ beat of a burst. The second is the number of wait states for every later beat of that burst. The block is meant to stand in for a memory subsystem while a bus master is being verified, so that master sees realistic, bank-dependent stall patterns.

The block takes control and address from the bus only on a NONSEQ beat. It then works out every later beat address itself from the latched burst type and transfer size, and it ignores HADDR on SEQ beats. It performs no protocol checking: every transfer completes with an OKAY response. A transfer that selects no configured bank still completes, with no wait states and zero read data. Bank placement and latencies are parameters, checked at elaboration for alignment, size and overlap. The storage is little-endian, 32 bits wide, and written per byte lane.

Top module: `ahbm_multibank_mem`

## Requirements
- R1: While reset is asserted and right after it, hreadyout is 1, hrdata is zero and hresp is 0 (OKAY).
- R2: An address selects bank b when start_b <= address <= end_b. The word used within the bank is (address - start_b)/4. A bank whose start, end and both wait counts are all zero is unused and never selected.
- R3: A NONSEQ transfer (htrans=2) to a bank holds hreadyout low for exactly that bank's first-access wait count of cycles in its data phase.
- R4: A SEQ transfer (htrans=3) holds hreadyout low for exactly the later-beat wait count of the bank chosen by the burst's NONSEQ beat.
- R5: SEQ beat addresses are generated internally, and HADDR is ignored on SEQ beats. For SINGLE (hburst=0), INCR (1), INCR4 (3), INCR8 (5) and INCR16 (7), each beat address is the previous beat address plus 2^hsize.
- R6: For WRAP4 (hburst=2), WRAP8 (4) and WRAP16 (6), the beat address wraps inside an aligned block of 4, 8 or 16 beats times 2^hsize bytes.
- R7: A transfer that selects no bank completes with no wait states, returns zero read data, and changes no stored word.
- R8: An IDLE (htrans=0) or BUSY (htrans=1) transfer completes with no wait states and writes nothing. A SEQ beat after a BUSY continues from the address after the last real beat.
- R9: Storage is little-endian: byte lane k (bits 8k+7..8k) holds byte offset k of a word. A write of size byte (hsize=0), halfword (1) or word (2) updates only the lanes addressed by haddr[1:0]. A read returns the whole 32-bit word.
- R10: hresp is always 0 (OKAY), for hits, misses and wait cycles alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address (used on NONSEQ beats only) |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hburst | input | 3 | Burst type, encoded as in R5 and R6 |
| hwdata | input | 32 | Write data, driven in the data phase |
| hready | input | 1 | Bus-wide ready; the address phase is taken when high |
| hreadyout | output | 1 | Low while this slave inserts wait states |
| hresp | output | 1 | Transfer response, always OKAY |
| hrdata | output | 32 | Read data, valid when hreadyout is high |

## Verification
Every result belongs to the data phase that starts one clock edge after the address phase is taken. A transfer's wait states therefore appear as consecutive low cycles of hreadyout, starting just after that edge. There are exactly n such cycles for a NONSEQ beat, m for a SEQ beat and none for a miss, IDLE or BUSY. Read data is due in the first half-cycle in which hreadyout is high again. A write lands on the storage at the edge that ends that cycle, so it is visible to the next read. The bench drives each address phase at a falling edge and counts the low hreadyout cycles at later falling edges. It samples hrdata at the falling edge where hreadyout has returned high, and it drives the next beat at that same falling edge, so checks follow the bus pipeline exactly.

// File: rtl/ahbm_pkg.sv
`timescale 1ns/1ps
package ahbm_pkg;
   localparam logic [1:0] TR_IDLE   = 2'd0;
   localparam logic [1:0] TR_BUSY   = 2'd1;
   localparam logic [1:0] TR_NONSEQ = 2'd2;
   localparam logic [1:0] TR_SEQ    = 2'd3;

   localparam logic [2:0] BU_WRAP4  = 3'd2;
   localparam logic [2:0] BU_WRAP8  = 3'd4;
   localparam logic [2:0] BU_WRAP16 = 3'd6;

   localparam int unsigned DATA_W = 32;
   localparam int unsigned LANES  = DATA_W / 8;

   // Byte-lane enables of one access, little-endian
   function automatic logic [LANES-1:0] lane_mask(input logic [1:0] off, input logic [2:0] size);
      case (size)
         3'd0:    lane_mask = 4'b0001 << off;
         3'd1:    lane_mask = off[1] ? 4'b1100 : 4'b0011;
         default: lane_mask = 4'b1111;
      endcase
   endfunction
endpackage

// File: rtl/ahbm_beat_addr.sv
`timescale 1ns/1ps
module ahbm_beat_addr
   import ahbm_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic [AW-1:0] cur,
   input  logic [2:0]    size,
   input  logic [2:0]    burst,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] step, span, mask, sum;
   logic [2:0]    beats_lb;
   logic          wrap;

   always_comb begin
      step = AW'(1) << size;
      sum  = cur + step;
      wrap = 1'b1;
      case (burst)
         BU_WRAP4:  beats_lb = 3'd2;
         BU_WRAP8:  beats_lb = 3'd3;
         BU_WRAP16: beats_lb = 3'd4;
         default: begin
            beats_lb = 3'd0;
            wrap     = 1'b0;
         end
      endcase
      span = step << beats_lb;
      mask = span - AW'(1);
      nxt  = wrap ? ((cur & ~mask) | (sum & mask)) : sum;
   end
endmodule

// File: rtl/ahbm_bank_decode.sv
`timescale 1ns/1ps
module ahbm_bank_decode #(
   parameter int unsigned AW     = 32,
   parameter int unsigned NBANK  = 6,
   parameter int unsigned WAIT_W = 4,
   parameter int unsigned BW     = 3,
   parameter logic [NBANK-1:0][AW-1:0]     BANK_LO = '0,
   parameter logic [NBANK-1:0][AW-1:0]     BANK_HI = '0,
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_NW = '0,
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_MW = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [BW-1:0] idx
);
   logic [NBANK-1:0] used;

   for (genvar b = 0; b < NBANK; b++) begin : g_used
      assign used[b] = (BANK_LO[b] != '0) || (BANK_HI[b] != '0) ||
                       (BANK_NW[b] != '0) || (BANK_MW[b] != '0);
   end

   // lowest index wins (banks are checked not to overlap anyway)
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int b = NBANK - 1; b >= 0; b--) begin
         if (used[b] && addr >= BANK_LO[b] && addr <= BANK_HI[b]) begin
            hit = 1'b1;
            idx = BW'(b);
         end
      end
   end
endmodule

// File: rtl/ahbm_bank_store.sv
`timescale 1ns/1ps
module ahbm_bank_store
   import ahbm_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IW    = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [LANES-1:0]  be,
   input  logic [IW-1:0]     widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IW-1:0]     ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int k = 0; k < LANES; k++) begin
            if (be[k]) mem[widx][8*k +: 8] <= wdata[8*k +: 8];
         end
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/ahbm_multibank_mem.sv
`timescale 1ns/1ps
module ahbm_multibank_mem
   import ahbm_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned NBANK  = 6,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned WAIT_W = 4,
   parameter logic [NBANK-1:0][AW-1:0] BANK_LO =
      {32'h0000_1000, 32'h0000_0300, 32'h0000_0200, 32'h0000_0100, 32'h0000_0000, 32'h0000_0000},
   parameter logic [NBANK-1:0][AW-1:0] BANK_HI =
      {32'h0000_103F, 32'h0000_033F, 32'h0000_023F, 32'h0000_013F, 32'h0000_003F, 32'h0000_0000},
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_NW = {4'd0, 4'd0, 4'd3, 4'd2, 4'd1, 4'd0},
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_MW = {4'd0, 4'd2, 4'd0, 4'd1, 4'd0, 4'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsel,
   input  logic [AW-1:0]     haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [2:0]        hburst,
   input  logic [DATA_W-1:0] hwdata,
   input  logic              hready,
   output logic              hreadyout,
   output logic              hresp,
   output logic [DATA_W-1:0] hrdata
);
   localparam int unsigned IW = $clog2(DEPTH);
   localparam int unsigned BW = (NBANK > 1) ? $clog2(NBANK) : 1;

   // ---------------- elaboration checks ----------------
   if (NBANK < 1 || NBANK > 6) begin : g_bad_nbank
      $error("NBANK must be 1..6");
   end
   if (DEPTH < 2 || DEPTH > 65536 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two in 2..65536");
   end
   if (WAIT_W < 1 || AW < IW + 3) begin : g_bad_width
      $error("WAIT_W or AW too small");
   end
   for (genvar b = 0; b < NBANK; b++) begin : g_cfg
      localparam bit USED_B = (BANK_LO[b] != '0) || (BANK_HI[b] != '0) ||
                              (BANK_NW[b] != '0) || (BANK_MW[b] != '0);
      if (BANK_LO[b][1:0] != 2'b00) begin : g_align
         $error("bank start must be word aligned");
      end
      if (USED_B && (BANK_HI[b] < BANK_LO[b] ||
                     (BANK_HI[b] - BANK_LO[b]) >= AW'(4 * DEPTH))) begin : g_span
         $error("bank range empty or larger than DEPTH words");
      end
      for (genvar j = b + 1; j < NBANK; j++) begin : g_pair
         localparam bit USED_J = (BANK_LO[j] != '0) || (BANK_HI[j] != '0) ||
                                 (BANK_NW[j] != '0) || (BANK_MW[j] != '0);
         if (USED_B && USED_J && BANK_LO[b] <= BANK_HI[j] && BANK_LO[j] <= BANK_HI[b]) begin : g_ovl
            $error("banks overlap");
         end
      end
   end

   // ---------------- burst context (latched on NONSEQ) ----------------
   logic [AW-1:0] bst_addr;
   logic [2:0]    bst_size, bst_burst;
   logic          bst_write, bst_hit;
   logic [BW-1:0] bst_bank;

   // ---------------- data-phase state ----------------
   logic              dp_valid, dp_write, dp_hit;
   logic [2:0]        dp_size;
   logic [1:0]        dp_off;
   logic [BW-1:0]     dp_bank;
   logic [IW-1:0]     dp_widx;
   logic [WAIT_W-1:0] wcnt;

   logic          accept, nonseq, dec_hit, beat_hit, waiting;
   logic [BW-1:0] dec_idx, beat_bank;
   logic [AW-1:0] seq_addr, beat_addr;
   logic [WAIT_W-1:0] beat_wait;

   ahbm_bank_decode #(
      .AW(AW), .NBANK(NBANK), .WAIT_W(WAIT_W), .BW(BW),
      .BANK_LO(BANK_LO), .BANK_HI(BANK_HI), .BANK_NW(BANK_NW), .BANK_MW(BANK_MW)
   ) dec_i (
      .addr (haddr),
      .hit  (dec_hit),
      .idx  (dec_idx)
   );

   ahbm_beat_addr #(.AW(AW)) step_i (
      .cur   (bst_addr),
      .size  (bst_size),
      .burst (bst_burst),
      .nxt   (seq_addr)
   );

   assign accept    = hsel && hready && htrans[1];
   assign nonseq    = (htrans == TR_NONSEQ);
   assign beat_addr = nonseq ? haddr : seq_addr;
   assign beat_bank = nonseq ? dec_idx : bst_bank;
   assign beat_hit  = nonseq ? dec_hit : bst_hit;
   assign beat_wait = !beat_hit ? '0 : (nonseq ? BANK_NW[beat_bank] : BANK_MW[beat_bank]);
   assign waiting   = dp_valid && (wcnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bst_addr  <= '0;
         bst_size  <= '0;
         bst_burst <= '0;
         bst_write <= 1'b0;
         bst_hit   <= 1'b0;
         bst_bank  <= '0;
         dp_valid  <= 1'b0;
         dp_write  <= 1'b0;
         dp_hit    <= 1'b0;
         dp_size   <= '0;
         dp_off    <= '0;
         dp_bank   <= '0;
         dp_widx   <= '0;
         wcnt      <= '0;
      end else if (waiting) begin
         wcnt <= wcnt - 1'b1;
      end else if (hready) begin
         dp_valid <= accept;
         if (accept) begin
            dp_write <= nonseq ? hwrite : bst_write;
            dp_size  <= nonseq ? hsize : bst_size;
            dp_hit   <= beat_hit;
            dp_bank  <= beat_bank;
            dp_off   <= beat_addr[1:0];
            dp_widx  <= IW'((beat_addr - BANK_LO[beat_bank]) >> 2);
            wcnt     <= beat_wait;
            bst_addr <= beat_addr;
            if (nonseq) begin
               bst_size  <= hsize;
               bst_burst <= hburst;
               bst_write <= hwrite;
               bst_bank  <= dec_idx;
               bst_hit   <= dec_hit;
            end
         end
      end
   end

   // ---------------- storage ----------------
   logic              wr_go;
   logic [LANES-1:0]  wr_be;
   logic [DATA_W-1:0] bank_rd [NBANK];

   assign wr_go = dp_valid && dp_write && dp_hit && (wcnt == '0);
   assign wr_be = lane_mask(dp_off, dp_size);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ahbm_bank_store #(.DEPTH(DEPTH), .IW(IW)) store_i (
         .clk   (clk),
         .we    (wr_go && (dp_bank == BW'(b))),
         .be    (wr_be),
         .widx  (dp_widx),
         .wdata (hwdata),
         .ridx  (dp_widx),
         .rdata (bank_rd[b])
      );
   end

   assign hreadyout = !waiting;
   assign hresp     = 1'b0;
   assign hrdata    = (dp_valid && !dp_write && dp_hit) ? bank_rd[dp_bank] : '0;
endmodule

// File: rtl/ahbm_checker.sv
`timescale 1ns/1ps
module ahbm_checker #(
   parameter int unsigned AW     = 32,
   parameter int unsigned NBANK  = 6,
   parameter int unsigned WAIT_W = 4,
   parameter logic [NBANK-1:0][AW-1:0]     BANK_LO = '0,
   parameter logic [NBANK-1:0][AW-1:0]     BANK_HI = '0,
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_NW = '0,
   parameter logic [NBANK-1:0][WAIT_W-1:0] BANK_MW = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hsel,
   input logic [AW-1:0] haddr,
   input logic [1:0]    htrans,
   input logic          hwrite,
   input logic          hready,
   input logic          hreadyout,
   input logic [31:0]   hrdata
);
   // independent range lookup: offset from start must not exceed span
   logic        now_hit;
   int unsigned now_bank;
   always_comb begin
      now_hit  = 1'b0;
      now_bank = 0;
      for (int b = 0; b < NBANK; b++) begin
         if (!now_hit && ({BANK_LO[b], BANK_HI[b], BANK_NW[b], BANK_MW[b]} != '0) &&
             haddr >= BANK_LO[b] && (haddr - BANK_LO[b]) <= (BANK_HI[b] - BANK_LO[b])) begin
            now_hit  = 1'b1;
            now_bank = b;
         end
      end
   end

   logic              ck_dp, ck_first, ck_miss, ck_wr, ck_bhit;
   int unsigned       ck_bbank;
   logic [WAIT_W-1:0] ck_exp;
   logic [WAIT_W:0]   ck_cnt;
   logic              take;
   assign take = hsel && hready && htrans[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_dp <= 1'b0; ck_first <= 1'b0; ck_miss <= 1'b0; ck_wr <= 1'b0;
         ck_bhit <= 1'b0; ck_bbank <= 0; ck_exp <= '0; ck_cnt <= '0;
      end else if (hready) begin
         ck_dp  <= take;
         ck_cnt <= '0;
         if (take) begin
            ck_first <= (htrans == 2'b10);
            if (htrans == 2'b10) begin
               ck_bhit  <= now_hit;
               ck_bbank <= now_bank;
               ck_wr    <= hwrite;
               ck_miss  <= !now_hit;
               ck_exp   <= now_hit ? BANK_NW[now_bank] : '0;
            end else begin
               ck_miss  <= !ck_bhit;
               ck_exp   <= ck_bhit ? BANK_MW[ck_bbank] : '0;
            end
         end
      end else if (ck_dp) begin
         ck_cnt <= ck_cnt + 1'b1;
      end
   end

   // R3: first beat stalls for the bank's first-access count
   a_r3_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_dp && ck_first && hreadyout) |-> (ck_cnt == {1'b0, ck_exp}));

   // R4: later beats stall for the burst bank's later-beat count
   a_r4_seq_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_dp && !ck_first && hreadyout) |-> (ck_cnt == {1'b0, ck_exp}));

   // R7: a read that hits no bank is ready at once with zero data
   a_r7_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_dp && ck_miss && !ck_wr) |-> (hreadyout && hrdata == 32'h0));

   // R8: IDLE and BUSY leave the next cycle ready
   a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel && hready && !htrans[1]) |=> hreadyout);
endmodule

bind ahbm_multibank_mem ahbm_checker #(
   .AW(AW), .NBANK(NBANK), .WAIT_W(WAIT_W),
   .BANK_LO(BANK_LO), .BANK_HI(BANK_HI), .BANK_NW(BANK_NW), .BANK_MW(BANK_MW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsel      (hsel),
   .haddr     (haddr),
   .htrans    (htrans),
   .hwrite    (hwrite),
   .hready    (hready),
   .hreadyout (hreadyout),
   .hrdata    (hrdata)
);

// File: tb/ahbm_multibank_mem_tb_top.sv
`timescale 1ns/1ps
module ahbm_multibank_mem_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsel = 1'b1;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'd0;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'd2;
   logic [2:0]  hburst = 3'd0;
   logic [31:0] hwdata = '0;
   logic        hready;
   logic        hreadyout, hresp;
   logic [31:0] hrdata;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;
   assign hready = hreadyout;

   ahbm_multibank_mem dut_i (
      .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
      .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
      .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
   );

   // {wr, size[1:0], addr[15:0], data[31:0], waits[3:0]}; reads expect data
   localparam int NV = 15;
   localparam logic [54:0] VEC [NV] = '{
      {1'b1, 2'd2, 16'h0004, 32'h1122_3344, 4'd1},
      {1'b1, 2'd2, 16'h0108, 32'hA5A5_0001, 4'd2},
      {1'b1, 2'd2, 16'h020C, 32'h0BAD_F00D, 4'd3},
      {1'b1, 2'd2, 16'h0310, 32'h5566_7788, 4'd0},
      {1'b1, 2'd2, 16'h1020, 32'hCAFE_1234, 4'd0},
      {1'b0, 2'd2, 16'h0004, 32'h1122_3344, 4'd1},
      {1'b0, 2'd2, 16'h0108, 32'hA5A5_0001, 4'd2},
      {1'b0, 2'd2, 16'h020C, 32'h0BAD_F00D, 4'd3},
      {1'b0, 2'd2, 16'h0310, 32'h5566_7788, 4'd0},
      {1'b0, 2'd2, 16'h1020, 32'hCAFE_1234, 4'd0},
      {1'b1, 2'd0, 16'h0005, 32'h0000_EE00, 4'd1},
      {1'b0, 2'd2, 16'h0004, 32'h1122_EE44, 4'd1},
      {1'b1, 2'd1, 16'h0312, 32'hBEEF_0000, 4'd0},
      {1'b0, 2'd2, 16'h0310, 32'hBEEF_7788, 4'd0},
      {1'b0, 2'd0, 16'h0007, 32'h1122_EE44, 4'd1}
   };

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one beat: address phase from the current falling edge, returns at the
   // falling edge where the data phase completes
   task automatic beat(input logic [1:0] tr, input logic [31:0] a, input logic w,
                       input logic [2:0] sz, input logic [2:0] bu, input logic [31:0] wd,
                       output int waits, output logic [31:0] rd);
      htrans = tr; haddr = a; hwrite = w; hsize = sz; hburst = bu;
      @(posedge clk);
      @(negedge clk);
      htrans = 2'd0;
      hwdata = wd;
      waits  = 0;
      while (!hreadyout && waits < 100) begin
         waits++;
         @(negedge clk);
      end
      rd = hrdata;
   endtask

   int          w;
   logic [31:0] r;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_eq("R1 hreadyout in reset", {31'b0, hreadyout}, 32'h1);
      chk_eq("R1 hrdata in reset", hrdata, 32'h0);
      chk_eq("R10 hresp in reset", {31'b0, hresp}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 hreadyout after reset", {31'b0, hreadyout}, 32'h1);

      // vector table: single NONSEQ transfers
      for (int i = 0; i < NV; i++) begin
         logic [54:0] v;
         v = VEC[i];
         beat(2'd2, {16'h0, v[51:36]}, v[54], {1'b0, v[53:52]}, 3'd0, v[35:4], w, r);
         chk_eq($sformatf("R3 vec %0d waits", i), w, {28'h0, v[3:0]});
         chk_eq($sformatf("R10 vec %0d hresp", i), {31'b0, hresp}, 32'h0);
         if (!v[54]) chk_eq($sformatf("R9 R2 vec %0d rdata", i), r, v[35:4]);
      end

      // R2 all-zero bank 0 must not claim address 0 (bank 1 does, 1 wait)
      beat(2'd2, 32'h0, 1'b1, 3'd2, 3'd0, 32'h0F0F_0F0F, w, r);
      chk_eq("R2 unused bank skipped, waits", w, 1);
      beat(2'd2, 32'h0, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R2 read at 0", r, 32'h0F0F_0F0F);

      // R2/R7 inclusive end and first miss past it
      beat(2'd2, 32'h3C, 1'b1, 3'd2, 3'd0, 32'h3C3C_3C3C, w, r);
      chk_eq("R2 last word waits", w, 1);
      beat(2'd2, 32'h40, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R7 miss waits", w, 0);
      chk_eq("R7 miss rdata", r, 32'h0);
      beat(2'd2, 32'h40, 1'b1, 3'd2, 3'd0, 32'hFFFF_FFFF, w, r);
      chk_eq("R7 miss write waits", w, 0);
      beat(2'd2, 32'h3C, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R7 neighbour unchanged", r, 32'h3C3C_3C3C);
      beat(2'd2, 32'h800, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R7 far miss rdata", r, 32'h0);
      chk_eq("R10 miss hresp", {31'b0, hresp}, 32'h0);

      // R4 R5 INCR4 halfwords in bank at 0x100 (n=2, m=1); HADDR junk on SEQ
      beat(2'd2, 32'h104, 1'b1, 3'd1, 3'd3, 32'h0000_AAA1, w, r);
      chk_eq("R3 incr4 first waits", w, 2);
      beat(2'd3, 32'hDEAD_0000, 1'b1, 3'd1, 3'd3, 32'hAAA2_0000, w, r);
      chk_eq("R4 incr4 beat1 waits", w, 1);
      beat(2'd3, 32'hDEAD_0000, 1'b1, 3'd1, 3'd3, 32'h0000_AAA3, w, r);
      chk_eq("R4 incr4 beat2 waits", w, 1);
      beat(2'd3, 32'hDEAD_0000, 1'b1, 3'd1, 3'd3, 32'hAAA4_0000, w, r);
      chk_eq("R4 incr4 beat3 waits", w, 1);
      beat(2'd2, 32'h104, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R5 incr4 word 0x104", r, 32'hAAA2_AAA1);
      beat(2'd2, 32'h108, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R5 incr4 word 0x108", r, 32'hAAA4_AAA3);

      // R6 R8 WRAP4 words from 0x38 with a BUSY mid-burst
      beat(2'd2, 32'h38, 1'b1, 3'd2, 3'd2, 32'h0000_0001, w, r);
      beat(2'd3, 32'h0, 1'b1, 3'd2, 3'd2, 32'h0000_0002, w, r);
      beat(2'd1, 32'h0, 1'b1, 3'd2, 3'd2, 32'hFFFF_FFFF, w, r);
      chk_eq("R8 busy waits", w, 0);
      beat(2'd3, 32'h0, 1'b1, 3'd2, 3'd2, 32'h0000_0003, w, r);
      chk_eq("R8 seq after busy waits", w, 0);
      beat(2'd3, 32'h0, 1'b1, 3'd2, 3'd2, 32'h0000_0004, w, r);
      beat(2'd0, 32'h0, 1'b1, 3'd2, 3'd0, 32'hFFFF_FFFF, w, r);
      chk_eq("R8 idle waits", w, 0);
      beat(2'd2, 32'h30, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R6 wrap4 word 0x30", r, 32'h3);
      beat(2'd2, 32'h34, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R6 wrap4 word 0x34", r, 32'h4);
      beat(2'd2, 32'h38, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R8 wrap4 word 0x38", r, 32'h1);
      beat(2'd2, 32'h3C, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R8 wrap4 word 0x3C", r, 32'h2);

      // R4 INCR words in bank at 0x300 (n=0, m=2)
      beat(2'd2, 32'h300, 1'b1, 3'd2, 3'd1, 32'h3000_0001, w, r);
      chk_eq("R3 incr first waits", w, 0);
      beat(2'd3, 32'h0, 1'b1, 3'd2, 3'd1, 32'h3000_0002, w, r);
      chk_eq("R4 incr beat1 waits", w, 2);
      beat(2'd3, 32'h0, 1'b1, 3'd2, 3'd1, 32'h3000_0003, w, r);
      chk_eq("R4 incr beat2 waits", w, 2);
      beat(2'd2, 32'h308, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R5 incr word 0x308", r, 32'h3000_0003);

      // R6 R9 WRAP4 bytes from 0x1022: 0x1022,0x1023,0x1020,0x1021
      beat(2'd2, 32'h1022, 1'b1, 3'd0, 3'd2, 32'h0011_0000, w, r);
      beat(2'd3, 32'h0, 1'b1, 3'd0, 3'd2, 32'h2200_0000, w, r);
      beat(2'd3, 32'h0, 1'b1, 3'd0, 3'd2, 32'h0000_0033, w, r);
      beat(2'd3, 32'h0, 1'b1, 3'd0, 3'd2, 32'h0000_4400, w, r);
      beat(2'd2, 32'h1020, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R6 R9 byte wrap word", r, 32'h2211_4433);
      beat(2'd2, 32'h1024, 1'b0, 3'd2, 3'd0, 32'h0, w, r);
      chk_eq("R6 byte wrap stayed in block", {31'b0, hresp}, 32'h0);

      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R1..all actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule